// File: doc/BRIEF.md
# Asynchronous Serial Transmitter/Receiver with Split Mode and Command Registers

This block is a character-oriented asynchronous serial port. A host writes a mode byte and a command byte through two separate register selects. The mode byte fixes the character format and the number of clocks per bit. The command byte switches the transmitter and receiver on and off, drives the two active-low modem control outputs, forces a break, clears the error flags and requests an internal reset. No write sequencing is shared between the two registers: each select always reaches its own register.

Bytes written to the data select go into a one-entry holding buffer. They are serialised LSB first on `txd`, with an optional parity bit and a programmable stop length. The receiver synchronises `rxd`, checks the start bit at its half-bit point and samples each following bit at mid-bit. The finished character is placed in a receive buffer. Parity, overrun and framing problems are recorded as sticky flags in the status byte.

Turning the transmitter off while a character is on the line does not cut that character short. The disable waits until the character has finished, and turning the transmitter back on before then cancels the waiting disable.

Top module: `async_serial_unit`

## Requirements
- R1: After reset the status byte reads 0x05 (bit 0 holding buffer empty, bit 2 transmitter empty, all other bits 0), and `txd`, `dtr_n` and `rts_n` are all high.
- R2: Mode bits [3:2] hold the character length minus five, giving 5 to 8 data bits. A transmitted frame is a low start bit, the data bits LSB first, an optional parity bit, and a high stop level.
- R3: Mode bit 4 enables a parity bit and mode bit 5 selects its sense: 1 is even (the data bits plus the parity bit hold an even number of ones) and 0 is odd.
- R4: Mode bits [1:0] set the clocks per bit: 01 gives 1, 10 gives 16 and 11 gives 64. Code 00 is treated as 1.
- R5: Mode bits [7:6] set the transmitted stop length: 00 and 01 give one bit, 10 gives one and a half bits (two clocks at one clock per bit), and 11 gives two bits. Back-to-back characters start one bit period times (1 + length + parity) plus the stop length plus one clock apart.
- R6: With reception enabled (command bit 2 set), a received character appears right-aligned on `rx_data` with status bit 1 set. A pulse on `rd_data` clears status bit 1.
- R7: A received parity bit that mismatches sets status bit 3. A stop bit sampled low sets status bit 5.
- R8: If a character completes while status bit 1 is still set, status bit 4 is set and `rx_data` takes the new character.
- R9: A command write with bit 4 set clears status bits 3, 4 and 5.
- R10: A command write drives `dtr_n` to the inverse of bit 1 and `rts_n` to the inverse of bit 5, from the next clock.
- R11: A command write with bit 0 clear, issued while a character is being sent, leaves the transmitter enabled until that character ends, and no further character is started. A command write with bit 0 set before the character ends cancels the pending disable.
- R12: With the transmitter disabled and idle, `txd` stays high. Command bit 3 forces `txd` low from the next clock for as long as it is set.
- R13: With command bit 2 clear, activity on `rxd` sets no status bit.
- R14: A command write with bit 6 set disables the transmitter and receiver, raises `dtr_n` and `rts_n`, empties the holding buffer and clears status bits 1, 3, 4 and 5, so the status byte reads 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 mode, 2 command |
| wr_data | input | 8 | Write data |
| rd_data | input | 1 | Receive buffer read strobe, clears status bit 1 |
| rx_data | output | 8 | Last received character, right-aligned |
| status | output | 8 | {2'b0, framing, overrun, parity, tx empty, rx ready, tx ready} |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| dtr_n | output | 1 | Active-low data terminal ready |
| rts_n | output | 1 | Active-low request to send |

## Verification
Some rules can be checked on every cycle: the modem outputs following a command write, `txd` staying high while disabled and idle and low during break, the transmitter staying enabled after a disable written mid-character, the error flags clearing, the read clearing the ready bit, and overrun being flagged. Other behaviours only show up in the bench's scenarios: frame contents and parity sense for each length, bit timing and stop length measured between start edges, mid-bit reception at every divide factor, the deferred disable and its cancellation across a whole character, and the internal reset.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int MAX_FACTOR = 64;
  localparam int CNT_W = $clog2(2 * MAX_FACTOR) + 1;
  localparam int CHAR_W = 8;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] fact;
  } mode_t;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

  function automatic logic [CNT_W-1:0] bit_cycles(logic [1:0] f);
    case (f)
      2'b10:   return CNT_W'(16);
      2'b11:   return CNT_W'(MAX_FACTOR);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stop_cycles(mode_t m);
    logic [CNT_W-1:0] f;
    f = bit_cycles(m.fact);
    case (m.stop)
      2'b10:   return CNT_W'((3 * int'(f) + 1) / 2);
      2'b11:   return f << 1;
      default: return f;
    endcase
  endfunction

  function automatic logic par_bit(logic [CHAR_W-1:0] d, logic [1:0] len, logic even);
    logic [CHAR_W-1:0] msk;
    logic ones;
    msk  = 8'hFF >> (2'd3 - len);
    ones = ^(d & msk);
    return even ? ones : ~ones;
  endfunction
endpackage

// File: rtl/asu_tx.sv
module asu_tx
  import asu_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  mode_t             mode,
  input  logic              start,
  input  logic [CHAR_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic              line
);
  phase_e            st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] sh;
  logic [CNT_W-1:0]  per;
  logic [CNT_W-1:0]  stop_len;
  logic [2:0]        last;
  logic              bit_end;

  assign per      = bit_cycles(mode.fact);
  assign stop_len = stop_cycles(mode);
  assign last     = 3'(mode.len) + 3'd4;
  assign bit_end  = (cnt == ((st == PH_STOP) ? stop_len : per));
  assign busy     = (st != PH_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (clr) begin
      st   <= PH_IDLE;
      cnt  <= CNT_W'(1);
      idx  <= '0;
      sh   <= '0;
      line <= 1'b1;
    end else if (st == PH_IDLE) begin
      if (start) begin
        st   <= PH_START;
        cnt  <= CNT_W'(1);
        sh   <= data;
        line <= 1'b0;
      end
    end else if (!bit_end) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      cnt <= CNT_W'(1);
      case (st)
        PH_START: begin
          st   <= PH_DATA;
          idx  <= '0;
          line <= sh[0];
        end
        PH_DATA: begin
          if (idx == last) begin
            if (mode.par_en) begin
              st   <= PH_PAR;
              line <= par_bit(sh, mode.len, mode.even);
            end else begin
              st   <= PH_STOP;
              line <= 1'b1;
            end
          end else begin
            idx  <= idx + 3'd1;
            line <= sh[idx + 3'd1];
          end
        end
        PH_PAR: begin
          st   <= PH_STOP;
          line <= 1'b1;
        end
        default: begin
          st   <= PH_IDLE;
          done <= 1'b1;
          line <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/asu_rx.sv
module asu_rx
  import asu_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic [1:0]        fact,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              even,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  phase_e            st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] sh;
  logic              pbad;
  logic [CNT_W-1:0]  per;
  logic [CNT_W-1:0]  half;
  logic [2:0]        last;

  assign per  = bit_cycles(fact);
  assign half = per >> 1;
  assign last = 3'(len) + 3'd4;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (clr) begin
      st   <= PH_IDLE;
      cnt  <= CNT_W'(1);
      idx  <= '0;
      sh   <= '0;
      pbad <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: begin
          if (!rxd) begin
            cnt  <= CNT_W'(1);
            idx  <= '0;
            sh   <= '0;
            pbad <= 1'b0;
            st   <= (half == '0) ? PH_DATA : PH_START;
          end
        end
        PH_START: begin
          if (cnt == half) begin
            cnt <= CNT_W'(1);
            st  <= rxd ? PH_IDLE : PH_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (cnt != per) begin
            cnt <= cnt + CNT_W'(1);
          end else begin
            cnt <= CNT_W'(1);
            case (st)
              PH_DATA: begin
                sh[idx] <= rxd;
                if (idx == last) st <= par_en ? PH_PAR : PH_STOP;
                else idx <= idx + 3'd1;
              end
              PH_PAR: begin
                pbad <= (rxd != par_bit(sh, len, even));
                st   <= PH_STOP;
              end
              default: begin
                st   <= PH_IDLE;
                done <= 1'b1;
                data <= sh;
                perr <= pbad;
                ferr <= ~rxd;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/async_serial_unit.sv
module async_serial_unit
  import asu_pkg::*;
#(
  parameter logic [7:0] MODE_RST = 8'h4E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_data,
  output logic [7:0] rx_data,
  output logic [7:0] status,
  output logic       txd,
  input  logic       rxd,
  output logic       dtr_n,
  output logic       rts_n
);
  mode_t             mode_q;
  logic              tx_en, tx_pend, rx_en, brk;
  logic [CHAR_W-1:0] hold;
  logic              hold_full;
  logic              rxrdy, pe, oe, fe;
  logic              rxd_s1, rxd_s2;
  logic              wr_mode, wr_cmd, wr_dat, soft_rst;
  logic              tx_start, tx_busy, tx_done, tx_line;
  logic              rx_done, rx_pe, rx_fe;
  logic [CHAR_W-1:0] rx_char;
  logic              clr_tx, clr_rx;

  assign wr_mode  = wr_en && (wr_sel == SEL_MODE);
  assign wr_cmd   = wr_en && (wr_sel == SEL_CMD);
  assign wr_dat   = wr_en && (wr_sel == SEL_DATA);
  assign soft_rst = wr_cmd && wr_data[6];
  assign clr_tx   = rst || wr_mode || soft_rst;
  assign clr_rx   = clr_tx || !rx_en;
  assign tx_start = hold_full && tx_en && !tx_pend && !tx_busy;
  assign status   = {2'b00, fe, oe, pe, !hold_full && !tx_busy, rxrdy, !hold_full};

  asu_tx i_tx (
    .clk(clk), .clr(clr_tx), .mode(mode_q), .start(tx_start), .data(hold),
    .busy(tx_busy), .done(tx_done), .line(tx_line)
  );

  asu_rx i_rx (
    .clk(clk), .clr(clr_rx), .fact(mode_q.fact), .len(mode_q.len),
    .par_en(mode_q.par_en), .even(mode_q.even), .rxd(rxd_s2),
    .done(rx_done), .data(rx_char), .perr(rx_pe), .ferr(rx_fe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= mode_t'(MODE_RST);
      tx_en     <= 1'b0;
      tx_pend   <= 1'b0;
      rx_en     <= 1'b0;
      brk       <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
      rxrdy     <= 1'b0;
      pe        <= 1'b0;
      oe        <= 1'b0;
      fe        <= 1'b0;
      rx_data   <= '0;
      rxd_s1    <= 1'b1;
      rxd_s2    <= 1'b1;
      txd       <= 1'b1;
      dtr_n     <= 1'b1;
      rts_n     <= 1'b1;
    end else begin
      rxd_s1 <= rxd;
      rxd_s2 <= rxd_s1;
      txd    <= brk ? 1'b0 : tx_line;
      if (wr_mode) mode_q <= mode_t'(wr_data);
      if (tx_start) hold_full <= 1'b0;
      if (wr_dat) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if ((tx_done || wr_mode) && tx_pend) begin
        tx_en   <= 1'b0;
        tx_pend <= 1'b0;
      end
      if (rd_data) rxrdy <= 1'b0;
      if (rx_done) begin
        rx_data <= rx_char;
        rxrdy   <= 1'b1;
        if (rxrdy && !rd_data) oe <= 1'b1;
        if (rx_pe) pe <= 1'b1;
        if (rx_fe) fe <= 1'b1;
      end
      if (wr_cmd) begin
        rx_en <= wr_data[2];
        brk   <= wr_data[3];
        dtr_n <= ~wr_data[1];
        rts_n <= ~wr_data[5];
        if (wr_data[0]) begin
          tx_en   <= 1'b1;
          tx_pend <= 1'b0;
        end else if ((tx_busy && !tx_done) || tx_start) begin
          tx_pend <= 1'b1;
        end else begin
          tx_en   <= 1'b0;
          tx_pend <= 1'b0;
        end
        if (wr_data[4]) begin
          pe <= 1'b0;
          oe <= 1'b0;
          fe <= 1'b0;
        end
        if (wr_data[6]) begin
          tx_en     <= 1'b0;
          tx_pend   <= 1'b0;
          rx_en     <= 1'b0;
          brk       <= 1'b0;
          dtr_n     <= 1'b1;
          rts_n     <= 1'b1;
          hold_full <= 1'b0;
          rxrdy     <= 1'b0;
          pe        <= 1'b0;
          oe        <= 1'b0;
          fe        <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/asu_checker.sv
module asu_checker
  import asu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       rd_data,
  input logic [7:0] status,
  input logic       txd,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       tx_en,
  input logic       brk,
  input logic       rx_done
);
  logic cmd_w;
  assign cmd_w = wr_en && (wr_sel == SEL_CMD);

  a_r10_modem_outputs: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && !wr_data[6]) |=> (dtr_n == !$past(wr_data[1])) && (rts_n == !$past(wr_data[5])));

  a_r12_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !tx_busy && !brk) |=> txd);

  a_r12_break_low: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  a_r11_disable_deferred: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && !wr_data[0] && !wr_data[6] && tx_busy && !tx_done) |=> tx_en);

  a_r9_errors_cleared: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wr_data[4]) |=> (status[5:3] == 3'b000));

  a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_done) |=> !status[1]);

  a_r8_overrun_flagged: assert property (@(posedge clk) disable iff (rst)
    (rx_done && status[1] && !rd_data && !(cmd_w && (wr_data[4] || wr_data[6]))) |=> status[4]);
endmodule

bind async_serial_unit asu_checker i_asu_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_data(rd_data), .status(status), .txd(txd), .dtr_n(dtr_n), .rts_n(rts_n),
  .tx_busy(tx_busy), .tx_done(tx_done), .tx_en(tx_en), .brk(brk), .rx_done(rx_done)
);

// File: tb/test_async_serial_unit.sv
module test_async_serial_unit;
  localparam int CLK_NS = 10;
  localparam logic [1:0] S_DATA = 2'd0, S_MODE = 2'd1, S_CMD = 2'd2;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_data = 1'b0, rxd = 1'b1;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rx_data, status;
  logic txd, dtr_n, rts_n;
  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 1'b0;

  async_serial_unit i_async_serial_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .rx_data(rx_data), .status(status), .txd(txd),
    .rxd(rxd), .dtr_n(dtr_n), .rts_n(rts_n)
  );

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int fact(logic [7:0] m);
    return (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
  endfunction
  function automatic int len_of(logic [7:0] m);
    return int'(m[3:2]) + 5;
  endfunction
  function automatic int stop_of(logic [7:0] m);
    int f = fact(m);
    return (m[7:6] == 2'b10) ? (3 * f + 1) / 2 : (m[7:6] == 2'b11) ? 2 * f : f;
  endfunction
  function automatic logic [7:0] mask_of(logic [7:0] m);
    return 8'hFF >> (8 - len_of(m));
  endfunction
  function automatic logic epar(logic [7:0] d, logic [7:0] m);
    logic ones = ^(d & mask_of(m));
    return m[5] ? ones : ~ones;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic tx_capture(input logic [7:0] m, output logic [7:0] d, output logic p, output logic s);
    int f = fact(m);
    d = 8'h00; p = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (f / 2) @(negedge clk);
    for (int i = 0; i < len_of(m); i++) begin
      repeat (f) @(negedge clk);
      d[i] = txd;
    end
    if (m[4]) begin
      repeat (f) @(negedge clk);
      p = txd;
    end
    repeat (f) @(negedge clk);
    s = txd;
  endtask

  task automatic rx_send(input logic [7:0] m, input logic [7:0] b, input bit bad_par, input bit bad_stop);
    int f = fact(m);
    @(negedge clk); rxd = 1'b0;
    repeat (f) @(negedge clk);
    for (int i = 0; i < len_of(m); i++) begin
      rxd = b[i];
      repeat (f) @(negedge clk);
    end
    if (m[4]) begin
      rxd = epar(b, m) ^ bad_par;
      repeat (f) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (f) @(negedge clk);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] m, input logic [7:0] b, input string req);
    logic [7:0] d; logic p, s;
    wr(S_DATA, b);
    tx_capture(m, d, p, s);
    check({req, " data"}, d, b & mask_of(m));
    if (m[4]) check("R3 parity", p, epar(b, m));
    check("R2 stop level", s, 1);
  endtask

  task automatic period_test(input logic [7:0] m);
    int t1, t2, f, nb;
    f = fact(m);
    nb = 1 + len_of(m) + (m[4] ? 1 : 0);
    t1 = 0; t2 = 0;
    wr(S_MODE, m);
    wr(S_CMD, 8'h01);
    fork
      begin
        while (txd !== 1'b0) @(negedge clk);
        t1 = cyc;
        repeat (nb * f) @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        t2 = cyc;
      end
      begin
        wr(S_DATA, 8'hA5);
        while (!status[0]) @(negedge clk);
        wr(S_DATA, 8'h5A);
      end
    join
    check("R4 R5 start-to-start period", t2 - t1, nb * f + stop_of(m) + 1);
    while (!status[2]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, b, d;
    logic p, s;
    int lows;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h05);
    check("R1 txd", txd, 1);
    check("R1 dtr_n", dtr_n, 1);
    check("R1 rts_n", rts_n, 1);

    // R10 modem outputs
    wr(S_CMD, 8'h22);
    check("R10 dtr_n low", dtr_n, 0);
    check("R10 rts_n low", rts_n, 0);
    wr(S_CMD, 8'h02);
    check("R10 rts_n high", rts_n, 1);
    check("R10 dtr_n still low", dtr_n, 0);

    // R12 break and idle level
    wr(S_CMD, 8'h08);
    repeat (2) @(negedge clk);
    check("R12 break forces low", txd, 0);
    wr(S_CMD, 8'h00);
    repeat (2) @(negedge clk);
    check("R12 idle disabled high", txd, 1);

    // R4 R5 bit timing and stop lengths
    period_test(8'hBE);
    period_test(8'h81);
    period_test(8'hDB);
    period_test(8'h4D);

    // R2 R3 directed transmit formats
    m = 8'h72; wr(S_MODE, m); wr(S_CMD, 8'h01);
    tx_check(m, 8'h13, "R2 len5 even");
    m = 8'h5A; wr(S_MODE, m);
    tx_check(m, 8'hFF, "R2 len7 odd");

    // R11 deferred disable
    m = 8'h4E; wr(S_MODE, m); wr(S_CMD, 8'h01);
    wr(S_DATA, 8'h00);
    fork
      tx_capture(m, d, p, s);
      begin repeat (40) @(negedge clk); wr(S_CMD, 8'h00); end
    join
    check("R11 char completes after disable", d, 8'h00);
    check("R11 stop after disable", s, 1);
    wr(S_DATA, 8'h5A);
    lows = 0;
    repeat (400) begin @(negedge clk); if (txd == 1'b0) lows++; end
    check("R11 no new char once disabled", lows, 0);
    check("R11 holding buffer kept", status[0], 0);
    wr(S_CMD, 8'h01);
    tx_capture(m, d, p, s);
    check("R11 held char sent after enable", d, 8'h5A);
    wr(S_DATA, 8'hC3);
    fork
      tx_capture(m, d, p, s);
      begin
        repeat (40) @(negedge clk); wr(S_CMD, 8'h00);
        repeat (5) @(negedge clk); wr(S_CMD, 8'h01);
      end
    join
    check("R11 cancel first char", d, 8'hC3);
    tx_check(m, 8'h3C, "R11 cancel keeps enabled");

    // R6 R7 R8 R9 receive directed
    m = 8'h7E; wr(S_MODE, m); wr(S_CMD, 8'h15);
    rx_send(m, 8'h96, 0, 0);
    check("R6 rx ready", status[1], 1);
    check("R6 rx data", rx_data, 8'h96);
    rd();
    check("R6 read clears ready", status[1], 0);
    rx_send(m, 8'h21, 1, 0);
    check("R7 parity error", status[3], 1);
    check("R7 no framing error", status[5], 0);
    rd();
    rx_send(m, 8'h44, 0, 1);
    check("R7 framing error", status[5], 1);
    wr(S_CMD, 8'h14);
    check("R9 errors cleared", status[5:3], 0);
    rd();
    rx_send(m, 8'h11, 0, 0);
    rx_send(m, 8'h22, 0, 0);
    check("R8 overrun", status[4], 1);
    check("R8 newest char kept", rx_data, 8'h22);
    wr(S_CMD, 8'h14);
    check("R9 overrun cleared", status[5:3], 0);
    rd();

    // R13 receiver disabled
    wr(S_CMD, 8'h00);
    rx_send(m, 8'h55, 0, 0);
    check("R13 disabled rx ignores line", status[1], 0);

    // R14 internal reset
    wr(S_CMD, 8'h27);
    rx_send(m, 8'h0F, 0, 1);
    wr(S_DATA, 8'h99);
    wr(S_CMD, 8'h40);
    check("R14 status after internal reset", status, 8'h05);
    check("R14 dtr_n", dtr_n, 1);
    check("R14 rts_n", rts_n, 1);
    repeat (4) @(negedge clk);

    // random formats, both directions
    for (int it = 0; it < 12; it++) begin
      m = 8'($urandom);
      if (m[1:0] == 2'b00) m[1:0] = 2'b10;
      b = 8'($urandom);
      wr(S_MODE, m);
      wr(S_CMD, 8'h15);
      rx_send(m, b, 0, 0);
      check("R6 random rx ready", status[1], 1);
      check("R6 random rx data", rx_data, b & mask_of(m));
      check("R7 random no errors", status[5:3], 0);
      rd();
      tx_check(m, b, "R2 random tx");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule